// File: doc/BRIEF.md
# Host Memory Access Port with Word Packing

This block is a slave port through which an external host reads and writes the on-chip program memory (24-bit words) and data memory (16-bit words) over a 16-bit bus. The host picks a target with a control write. That write either sets a word address and a memory select, or it sets the overlay pages. The host then streams data words. The port splits each program word into two bus transfers, moves each data word in one transfer, steps the internal address after each whole word, and maps the overlay window of each memory onto the page selected for it.

Toward the memories, the port raises a request with address, page, direction and write data. It holds that request until a grant arrives. While a request is pending, the port reports busy and ignores host strobes. The overlay page selections in this port belong to it alone and are not shared with any other transfer engine.

Top module: `hdp_port`

## Requirements
- R1: After reset, no memory request is raised, the port is not busy and no read data is flagged valid.
- R2: With the data memory selected, each host data transfer moves one 16-bit word, bits 15:8 as the upper byte and bits 7:0 as the lower byte, in both directions.
- R3: With the program memory selected, a 24-bit word takes two transfers. The first carries bits 23:8 of the word. The second carries bits 7:0 of the word in bus bits 7:0, and on reads bus bits 15:8 of that second transfer are zero.
- R4: On a program memory write, bus bits 15:8 of the second transfer have no effect on the stored word.
- R5: A control write (select high) with bus bit 15 at 0 loads the address. Bit 14 picks the memory (0 = program, 1 = data) and bits 13:0 give the word address.
- R6: A control write with bus bit 15 at 1 loads the overlay pages: bits 7:4 for the data memory and bits 3:0 for the program memory. Accesses inside a memory's overlay window carry that memory's page on the request.
- R7: Program memory addresses 0x0000–0x1FFF are fixed and carry page 0 whatever the program page. Addresses 0x2000–0x3FFF form the program overlay window.
- R8: Data memory addresses 0x2000–0x3FFF are fixed and carry page 0. Addresses 0x0000–0x1FFF form the data overlay window.
- R9: The address increases by one after each completed word: after the single data transfer, or after the second program transfer.
- R10: An address load returns the program packing to the first transfer of a word.
- R11: Only pages 0, 4 and 5 are valid for an overlay window. With any other page loaded, accesses to that window raise no memory request, reads return zero and writes are dropped, while the address still advances.
- R12: A raised memory request keeps its address, page and direction steady until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe, one cycle |
| hostRd | input | 1 | Host read strobe, one cycle |
| hostSel | input | 1 | 1 = control (address/page) write, 0 = data transfer |
| hostWdata | input | 16 | Host write bus |
| hostRdata | output | 16 | Read data for the host |
| hostRvalid | output | 1 | One-cycle pulse: hostRdata holds a new transfer |
| hostBusy | output | 1 | Memory access pending; host strobes ignored |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memIsDm | output | 1 | 1 = data memory, 0 = program memory |
| memAddr | output | 14 | Word address |
| memPage | output | 4 | Overlay page, 0 in fixed windows |
| memWdata | output | 24 | Write word (data memory uses bits 15:0) |
| memRdata | input | 24 | Read word, valid in the grant cycle |
| memGnt | input | 1 | Grant; completes the request that edge |

## Verification
The bench builds the port with its default parameters: a 14-bit word address, 4-bit page fields, and a valid-page mask that admits pages 0, 4 and 5. These settings put both the fixed and the overlay window of each memory within reach, along with the valid pages and an invalid page (3). A memory model keyed on memory, page and address shows where each word actually landed. This exposes mis-packed bytes, wrong page routing and dropped or misplaced writes.

// File: rtl/hdp_pkg.sv
package hdp_pkg;
  // Strobes from the sequencer to the datapath, one per cycle
  typedef struct packed {
    logic ldAddr;  // load memory select and word address
    logic ldPage;  // load both overlay page fields
    logic ldHold;  // keep first program transfer (bits 23:8)
    logic ldWrDm;  // form data-memory write word
    logic ldWrPm;  // form program-memory write word from hold + low byte
    logic capRd;   // capture the granted read word
    logic rdZero;  // present zero (invalid overlay read)
    logic rdLow;   // present kept low byte of a program word
    logic incAddr; // step the word address
  } hdpStrobe_t;

  typedef enum logic {ST_IDLE, ST_MEM} hdpState_t;
endpackage

// File: rtl/hdp_ctrl.sv
module hdp_ctrl
  import hdp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic       hostSel,
  input  logic       ctlPageBit,
  input  logic       isDm,
  input  logic       accessOk,
  input  logic       memGnt,
  output hdpStrobe_t stb,
  output logic       memReq,
  output logic       memWe,
  output logic       hostBusy,
  output logic       hostRvalid
);
  hdpState_t state, nState;
  logic phase, nPhase;
  logic pendWe, nWe;
  logic nRvalid;

  always_comb begin
    stb     = '0;
    nState  = state;
    nPhase  = phase;
    nWe     = pendWe;
    nRvalid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (hostWr && hostSel) begin
          if (ctlPageBit) stb.ldPage = 1'b1;
          else begin
            stb.ldAddr = 1'b1;
            nPhase     = 1'b0;
          end
        end else if (hostWr) begin
          if (isDm) begin
            if (accessOk) begin
              stb.ldWrDm = 1'b1;
              nState     = ST_MEM;
              nWe        = 1'b1;
            end else stb.incAddr = 1'b1;
          end else if (!phase) begin
            stb.ldHold = 1'b1;
            nPhase     = 1'b1;
          end else if (accessOk) begin
            stb.ldWrPm = 1'b1;
            nState     = ST_MEM;
            nWe        = 1'b1;
          end else begin
            stb.incAddr = 1'b1;
            nPhase      = 1'b0;
          end
        end else if (hostRd && !hostSel) begin
          if (isDm) begin
            if (accessOk) begin
              nState = ST_MEM;
              nWe    = 1'b0;
            end else begin
              stb.rdZero  = 1'b1;
              stb.incAddr = 1'b1;
              nRvalid     = 1'b1;
            end
          end else if (!phase) begin
            if (accessOk) begin
              nState = ST_MEM;
              nWe    = 1'b0;
            end else begin
              stb.rdZero = 1'b1;
              nRvalid    = 1'b1;
              nPhase     = 1'b1;
            end
          end else begin
            stb.rdLow   = 1'b1;
            stb.incAddr = 1'b1;
            nRvalid     = 1'b1;
            nPhase      = 1'b0;
          end
        end
      end
      ST_MEM: begin
        if (memGnt) begin
          nState = ST_IDLE;
          if (pendWe) begin
            stb.incAddr = 1'b1;
            nPhase      = 1'b0;
          end else begin
            stb.capRd = 1'b1;
            nRvalid   = 1'b1;
            if (isDm) stb.incAddr = 1'b1;
            else      nPhase      = 1'b1;
          end
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phase      <= 1'b0;
      pendWe     <= 1'b0;
      hostRvalid <= 1'b0;
    end else begin
      state      <= nState;
      phase      <= nPhase;
      pendWe     <= nWe;
      hostRvalid <= nRvalid;
    end
  end

  assign memReq   = (state == ST_MEM);
  assign memWe    = pendWe;
  assign hostBusy = (state == ST_MEM);
endmodule

// File: rtl/hdp_datapath.sv
module hdp_datapath
  import hdp_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 4,
  parameter logic [(1<<PAGE_W)-1:0] VALID_PAGES = 16'h0031
) (
  input  logic              clk,
  input  logic              rstN,
  input  hdpStrobe_t        stb,
  input  logic [15:0]       hostWdata,
  input  logic [23:0]       memRdata,
  output logic              isDm,
  output logic              accessOk,
  output logic [15:0]       hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PAGE_W-1:0] memPage,
  output logic [23:0]       memWdata
);
  localparam int TOP = ADDR_W - 1;
  localparam int DM_LO = 4;

  logic [PAGE_W-1:0] dmPage, pmPage, selPage;
  logic [15:0]       holdHi;
  logic [7:0]        lowByte;
  logic              ovlWin;

  // Program overlay sits in the upper half, data overlay in the lower half
  assign ovlWin   = isDm ? !memAddr[TOP] : memAddr[TOP];
  assign selPage  = isDm ? dmPage : pmPage;
  assign memPage  = ovlWin ? selPage : '0;
  assign accessOk = !ovlWin || VALID_PAGES[selPage];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isDm      <= 1'b0;
      memAddr   <= '0;
      dmPage    <= '0;
      pmPage    <= '0;
      holdHi    <= '0;
      lowByte   <= '0;
      hostRdata <= '0;
      memWdata  <= '0;
    end else begin
      if (stb.ldAddr) begin
        isDm    <= hostWdata[14];
        memAddr <= hostWdata[ADDR_W-1:0];
      end else if (stb.incAddr) begin
        memAddr <= memAddr + 1'b1;
      end
      if (stb.ldPage) begin
        dmPage <= hostWdata[DM_LO +: PAGE_W];
        pmPage <= hostWdata[PAGE_W-1:0];
      end
      if (stb.ldHold) holdHi <= hostWdata;
      if (stb.ldWrDm) memWdata <= {8'h00, hostWdata};
      if (stb.ldWrPm) memWdata <= {holdHi, hostWdata[7:0]};
      if (stb.capRd) begin
        if (isDm) hostRdata <= memRdata[15:0];
        else begin
          hostRdata <= memRdata[23:8];
          lowByte   <= memRdata[7:0];
        end
      end
      if (stb.rdZero) begin
        hostRdata <= '0;
        lowByte   <= '0;
      end
      if (stb.rdLow) hostRdata <= {8'h00, lowByte};
    end
  end
endmodule

// File: rtl/hdp_port.sv
module hdp_port
  import hdp_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 4,
  parameter logic [(1<<PAGE_W)-1:0] VALID_PAGES = 16'h0031
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              hostSel,
  input  logic [15:0]       hostWdata,
  output logic [15:0]       hostRdata,
  output logic              hostRvalid,
  output logic              hostBusy,
  output logic              memReq,
  output logic              memWe,
  output logic              memIsDm,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PAGE_W-1:0] memPage,
  output logic [23:0]       memWdata,
  input  logic [23:0]       memRdata,
  input  logic              memGnt
);
  hdpStrobe_t stb;
  logic       accessOk;

  hdp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostSel(hostSel),
    .ctlPageBit(hostWdata[15]), .isDm(memIsDm), .accessOk(accessOk),
    .memGnt(memGnt), .stb(stb), .memReq(memReq), .memWe(memWe),
    .hostBusy(hostBusy), .hostRvalid(hostRvalid)
  );

  hdp_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .VALID_PAGES(VALID_PAGES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWdata(hostWdata), .memRdata(memRdata),
    .isDm(memIsDm), .accessOk(accessOk), .hostRdata(hostRdata),
    .memAddr(memAddr), .memPage(memPage), .memWdata(memWdata)
  );
endmodule

// File: rtl/hdp_port_chk.sv
module hdp_port_chk #(
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 4,
  parameter logic [(1<<PAGE_W)-1:0] VALID_PAGES = 16'h0031
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memIsDm,
  input logic [ADDR_W-1:0] memAddr,
  input logic [PAGE_W-1:0] memPage,
  input logic              memGnt,
  input logic              hostBusy
);
  // R12: pending request stays steady until granted
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memPage)
                          && $stable(memIsDm) && $stable(memWe));

  // R11: no request is ever raised toward an invalid page
  p_valid_page_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> VALID_PAGES[memPage]);

  // R7: program fixed window carries page 0
  p_pm_fixed_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memIsDm && !memAddr[ADDR_W-1] |-> memPage == '0);

  // R8: data fixed window carries page 0
  p_dm_fixed_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memIsDm && memAddr[ADDR_W-1] |-> memPage == '0);

  // R1: nothing pending right after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> !memReq && !hostBusy);
endmodule

bind hdp_port hdp_port_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .VALID_PAGES(VALID_PAGES)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memIsDm(memIsDm),
  .memAddr(memAddr), .memPage(memPage), .memGnt(memGnt), .hostBusy(hostBusy)
);

// File: tb/hdp_port_test.sv
module hdp_port_test;
  logic clk = 0, rstN = 0;
  logic hostWr = 0, hostRd = 0, hostSel = 0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic hostRvalid, hostBusy, memReq, memWe, memIsDm;
  logic [13:0] memAddr;
  logic [3:0]  memPage;
  logic [23:0] memWdata;
  logic [23:0] memRdata = '0;
  logic memGnt = 0;

  int errors = 0, checks = 0;
  int grantCount = 0;
  logic [3:0] lastPage;
  logic [13:0] lastAddr;
  logic [23:0] memModel [int];
  int waitCnt = 0;

  always #2 clk = ~clk;

  hdp_port uut (.*);

  // Memory model: grants one cycle after a request appears
  always @(negedge clk) begin
    if (memGnt) memGnt <= 0;
    else if (memReq) begin
      if (waitCnt == 1) begin
        int k;
        k = (int'(memIsDm) << 20) | (int'(memPage) << 16) | int'(memAddr);
        memGnt   <= 1;
        waitCnt  <= 0;
        grantCount <= grantCount + 1;
        lastPage <= memPage;
        lastAddr <= memAddr;
        if (memWe) memModel[k] = memIsDm ? {8'h00, memWdata[15:0]} : memWdata;
        else memRdata <= memModel.exists(k) ? memModel[k] : 24'h0;
      end else waitCnt <= waitCnt + 1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hWrite(logic sel, logic [15:0] d);
    @(negedge clk);
    hostSel = sel; hostWdata = d; hostWr = 1;
    @(negedge clk);
    hostWr = 0;
    while (hostBusy) @(negedge clk);
  endtask

  task automatic hRead(output logic [15:0] d);
    @(negedge clk);
    hostSel = 0; hostRd = 1;
    @(negedge clk);
    hostRd = 0;
    for (int i = 0; i < 20 && !hostRvalid; i++) @(negedge clk);
    d = hostRvalid ? hostRdata : 16'hDEAD;
  endtask

  // op: 0 = control write, 1 = data write, 2 = data read and compare
  typedef struct packed { logic [1:0] op; logic [15:0] d; logic [15:0] exp; } vec_t;
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h4010, 16'h0},    // R5 DM address 0x10
    '{2'd1, 16'h1234, 16'h0},    // R2
    '{2'd1, 16'hBEEF, 16'h0},    // R9 next address
    '{2'd0, 16'h4010, 16'h0},
    '{2'd2, 16'h0, 16'h1234},    // R2
    '{2'd2, 16'h0, 16'hBEEF},    // R9
    '{2'd0, 16'h0020, 16'h0},    // PM address 0x20
    '{2'd1, 16'hABCD, 16'h0},    // R3 first transfer
    '{2'd1, 16'h77EF, 16'h0},    // R4 upper byte ignored
    '{2'd1, 16'h1122, 16'h0},
    '{2'd1, 16'h0033, 16'h0},
    '{2'd0, 16'h0020, 16'h0},
    '{2'd2, 16'h0, 16'hABCD},    // R3
    '{2'd2, 16'h0, 16'h00EF},    // R3 R4 zero upper on read
    '{2'd2, 16'h0, 16'h1122},    // R9
    '{2'd2, 16'h0, 16'h0033},
    '{2'd0, 16'h0010, 16'h0},    // R5 PM address 0x10
    '{2'd1, 16'h5555, 16'h0},
    '{2'd1, 16'h0066, 16'h0},
    '{2'd0, 16'h4010, 16'h0}     // DM word must be untouched
  };

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int g0;
    repeat (3) @(negedge clk);
    check("R1 memReq", memReq, 0);
    check("R1 busy", hostBusy, 0);
    check("R1 rvalid", hostRvalid, 0);
    rstN = 1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == 0) hWrite(1, VECS[i].d);
      else if (VECS[i].op == 1) hWrite(0, VECS[i].d);
      else begin
        hRead(r);
        check($sformatf("R2/R3/R9 vector %0d", i), r, VECS[i].exp);
      end
    end
    hRead(r); check("R5 memory select", r, 16'h1234);

    // R10: address load restarts packing
    hWrite(1, 16'h0020); hWrite(0, 16'hAAAA); hWrite(1, 16'h0020);
    hRead(r); check("R10 phase reset", r, 16'hABCD);
    hRead(r); check("R10 second", r, 16'h00EF);

    // R6: pages DM=4, PM=5
    hWrite(1, 16'h8045);
    hWrite(1, 16'h2005); hWrite(0, 16'h0102); hWrite(0, 16'h0003);
    check("R6 pm page", lastPage, 4'd5);
    check("R6 pm addr", lastAddr, 14'h2005);
    hWrite(1, 16'h4007); hWrite(0, 16'h9999);
    check("R6 dm page", lastPage, 4'd4);
    hWrite(1, 16'h0005); hWrite(0, 16'h0A0B); hWrite(0, 16'h000C);
    check("R7 pm fixed page", lastPage, 4'd0);
    hWrite(1, 16'h6007); hWrite(0, 16'h4444);
    check("R8 dm fixed page", lastPage, 4'd0);
    hWrite(1, 16'h2005); hRead(r); check("R6 readback hi", r, 16'h0102);
    hRead(r); check("R6 readback lo", r, 16'h0003);

    // R11: invalid page 3 for both memories
    hWrite(1, 16'h8033);
    g0 = grantCount;
    hWrite(1, 16'h2005); hWrite(0, 16'hFFFF); hWrite(0, 16'h00FF);
    hWrite(1, 16'h2005); hRead(r); check("R11 pm read zero", r, 16'h0000);
    hRead(r); check("R11 pm low zero", r, 16'h0000);
    hWrite(1, 16'h4007); hRead(r); check("R11 dm read zero", r, 16'h0000);
    check("R11 no request", grantCount, g0);
    hWrite(1, 16'h6007); hRead(r); check("R8 fixed under bad page", r, 16'h4444);
    hWrite(1, 16'h8045);
    hWrite(1, 16'h2005); hRead(r); check("R11 write dropped", r, 16'h0102);
    hWrite(1, 16'h4007); hRead(r); check("R6 dm page readback", r, 16'h9999);
    hWrite(1, 16'h8000);
    hWrite(1, 16'h4007); hRead(r); check("R6 page 0 separate", r, 16'h0000);
    hWrite(1, 16'h0005); hRead(r); check("R7 fixed ignores page", r, 16'h0A0B);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule